// File: doc/BRIEF.md
# Timer Event Flag and Interrupt Request Unit

This block keeps the eight-bit event flag register shared by two timers on a byte-wide bus. Event strobes arrive from the counter and compare logic around it: overflow, compare hits with a "forced" qualifier, a capture-pin event and a counter-at-TOP event. The block latches each strobe into a sticky flag, clears flags by write-one or by an acknowledge from the interrupt controller, and drives one request line per flag. A request is raised only when the flag, its enable and the global interrupt enable are all 1.

Every event is sampled only on cycles where the timer clock-enable `tick` is high. Compare hits are held for one extra timer tick before the flag rises. A compare hit marked as forced never reaches its flag. The capture flag follows either the pin or the TOP event, as chosen by a mode input. When a set and a clear hit the same flag in one cycle, the set wins, so no event is lost.

Top module: `tef_flags`

## Requirements
- R1: After a synchronous reset `rd_data` and `irq` are both 8'h00.
- R2: Flag positions in `rd_data`, `wr_data`, `ack`, `irq_en` and `irq` are: bit 0 timer0 overflow, bit 1 timer0 compare A, bit 2 timer0 compare B, bit 3 timer1 overflow, bit 4 timer1 compare A, bit 5 timer1 compare B, bit 7 timer1 capture. Bit 6 is never set and always reads 0.
- R3: With `wr_en`=1, each 1 in `wr_data` clears that flag at the next edge. Each 0 leaves its flag as it was.
- R4: An `ack` bit at 1 clears the matching flag at the next edge.
- R5: A compare hit sampled on a tick cycle sets its flag at the edge of the next tick cycle, not at the edge of the hit cycle. Non-tick cycles in between do not count.
- R6: A compare hit whose forced qualifier is 1 on the same tick sets no flag.
- R7: With `cap_top_sel`=0 the capture flag sets on `cap_pin_ev`, and `c1_top_ev` is ignored. With `cap_top_sel`=1 it sets on `c1_top_ev`, and `cap_pin_ev` is ignored.
- R8: Overflow and capture events set their flag at the edge of the tick cycle they occur in. Any event on a cycle with `tick`=0 is ignored.
- R9: `irq` equals the flag value of the same cycle ANDed with `irq_en` and `gie` as sampled at the previous edge.
- R10: A set and a clear (write-one or ack) of the same flag in one cycle leave the flag at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timer clock-enable pulse |
| gie | input | 1 | Global interrupt enable |
| irq_en | input | 8 | Per-flag interrupt enables |
| c0_ovf_ev | input | 1 | Timer0 overflow strobe |
| c0_hit_a | input | 1 | Timer0 compare A hit |
| c0_hit_b | input | 1 | Timer0 compare B hit |
| c0_frc_a | input | 1 | Timer0 compare A hit is forced |
| c0_frc_b | input | 1 | Timer0 compare B hit is forced |
| c1_ovf_ev | input | 1 | Timer1 overflow strobe |
| c1_hit_a | input | 1 | Timer1 compare A hit |
| c1_hit_b | input | 1 | Timer1 compare B hit |
| c1_frc_a | input | 1 | Timer1 compare A hit is forced |
| c1_frc_b | input | 1 | Timer1 compare B hit is forced |
| cap_pin_ev | input | 1 | Capture-pin event |
| c1_top_ev | input | 1 | Timer1 reached TOP |
| cap_top_sel | input | 1 | 1: capture flag follows TOP event |
| wr_en | input | 1 | Flag register write strobe |
| wr_data | input | 8 | Write data, 1 clears |
| ack | input | 8 | Per-vector acknowledge |
| rd_data | output | 8 | Flag register readback |
| irq | output | 8 | Per-flag interrupt request |

## Verification
A flag set and a flag clear can fall in the same cycle: an overflow, capture or delayed compare event can coincide with a write-one or with an acknowledge of the same bit. The bench provokes this directly, with an overflow plus a write-one and a capture plus an ack, and also at random through sparse events mixed with random clear masks. In each case the flag is judged after the edge against a bench model in which set has priority. The compare delay is checked with non-tick gaps between the hit and the following tick, so a design that counts system cycles instead of ticks shows up.

// File: rtl/tef_pkg.sv
package tef_pkg;
  localparam int FLAG_W = 8;
  localparam int NCMP   = 4;

  localparam int B_T0_OVF  = 0;
  localparam int B_T0_CMPA = 1;
  localparam int B_T0_CMPB = 2;
  localparam int B_T1_OVF  = 3;
  localparam int B_T1_CMPA = 4;
  localparam int B_T1_CMPB = 5;
  localparam int B_RSVD    = 6;
  localparam int B_T1_CAP  = 7;

  // compare lanes inside the delay unit
  localparam int L_T0A = 0;
  localparam int L_T0B = 1;
  localparam int L_T1A = 2;
  localparam int L_T1B = 3;

  localparam logic [FLAG_W-1:0] KEEP_MASK = ~(FLAG_W'(1) << B_RSVD);

  typedef enum logic {CAP_FROM_PIN = 1'b0, CAP_FROM_TOP = 1'b1} cap_src_e;
endpackage

// File: rtl/tef_cmp_delay.sv
module tef_cmp_delay #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [N-1:0] hit,
  input  logic [N-1:0] frc,
  output logic [N-1:0] fire
);
  for (genvar k = 0; k < N; k++) begin : g_lane
    logic pend_q;
    // a non-forced hit is armed on its tick and released on the next tick
    always_ff @(posedge clk) begin
      if (rst)       pend_q <= 1'b0;
      else if (tick) pend_q <= hit[k] & ~frc[k];
    end
    assign fire[k] = tick & pend_q;
  end
endmodule

// File: rtl/tef_flag_bank.sv
module tef_flag_bank #(
  parameter int             W    = 8,
  parameter logic [W-1:0]   KEEP = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] flags_q,
  output logic [W-1:0] flags_d
);
  // set has priority over clear; unkept bits stay zero
  assign flags_d = (set | (flags_q & ~clr)) & KEEP;

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= flags_d;
  end
endmodule

// File: rtl/tef_irq_gate.sv
module tef_irq_gate #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] flags_d,
  input  logic [W-1:0] en,
  input  logic         gie,
  output logic [W-1:0] irq_q
);
  always_ff @(posedge clk) begin
    if (rst) irq_q <= '0;
    else     irq_q <= flags_d & en & {W{gie}};
  end
endmodule

// File: rtl/tef_flags.sv
module tef_flags
  import tef_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              gie,
  input  logic [FLAG_W-1:0] irq_en,
  input  logic              c0_ovf_ev,
  input  logic              c0_hit_a,
  input  logic              c0_hit_b,
  input  logic              c0_frc_a,
  input  logic              c0_frc_b,
  input  logic              c1_ovf_ev,
  input  logic              c1_hit_a,
  input  logic              c1_hit_b,
  input  logic              c1_frc_a,
  input  logic              c1_frc_b,
  input  logic              cap_pin_ev,
  input  logic              c1_top_ev,
  input  logic              cap_top_sel,
  input  logic              wr_en,
  input  logic [FLAG_W-1:0] wr_data,
  input  logic [FLAG_W-1:0] ack,
  output logic [FLAG_W-1:0] rd_data,
  output logic [FLAG_W-1:0] irq
);
  logic [NCMP-1:0]   hit_v, frc_v, fire_v;
  logic [FLAG_W-1:0] set_v, clr_v, flags_q, flags_d;
  logic              cap_ev;
  cap_src_e          cap_src;

  assign hit_v[L_T0A] = c0_hit_a;
  assign hit_v[L_T0B] = c0_hit_b;
  assign hit_v[L_T1A] = c1_hit_a;
  assign hit_v[L_T1B] = c1_hit_b;
  assign frc_v[L_T0A] = c0_frc_a;
  assign frc_v[L_T0B] = c0_frc_b;
  assign frc_v[L_T1A] = c1_frc_a;
  assign frc_v[L_T1B] = c1_frc_b;

  tef_cmp_delay #(.N(NCMP)) u_cmp (
    .clk (clk),
    .rst (rst),
    .tick(tick),
    .hit (hit_v),
    .frc (frc_v),
    .fire(fire_v)
  );

  assign cap_src = cap_src_e'(cap_top_sel);
  always_comb begin
    case (cap_src)
      CAP_FROM_TOP: cap_ev = c1_top_ev;
      default:      cap_ev = cap_pin_ev;
    endcase
  end

  always_comb begin
    set_v            = '0;
    set_v[B_T0_OVF]  = tick & c0_ovf_ev;
    set_v[B_T0_CMPA] = fire_v[L_T0A];
    set_v[B_T0_CMPB] = fire_v[L_T0B];
    set_v[B_T1_OVF]  = tick & c1_ovf_ev;
    set_v[B_T1_CMPA] = fire_v[L_T1A];
    set_v[B_T1_CMPB] = fire_v[L_T1B];
    set_v[B_T1_CAP]  = tick & cap_ev;
  end

  assign clr_v = (wr_data & {FLAG_W{wr_en}}) | ack;

  tef_flag_bank #(.W(FLAG_W), .KEEP(KEEP_MASK)) u_bank (
    .clk    (clk),
    .rst    (rst),
    .set    (set_v),
    .clr    (clr_v),
    .flags_q(flags_q),
    .flags_d(flags_d)
  );

  tef_irq_gate #(.W(FLAG_W)) u_gate (
    .clk    (clk),
    .rst    (rst),
    .flags_d(flags_d),
    .en     (irq_en),
    .gie    (gie),
    .irq_q  (irq)
  );

  assign rd_data = flags_q;
endmodule

// File: rtl/tef_flags_chk.sv
module tef_flags_chk (
  input logic       clk,
  input logic       rst,
  input logic       tick,
  input logic       gie,
  input logic       c0_ovf_ev,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] ack,
  input logic [7:0] rd_data,
  input logic [7:0] irq
);
  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (rst)
    rd_data[6] == 1'b0);

  p_irq_has_flag_r9: assert property (@(posedge clk) disable iff (rst)
    (irq & ~rd_data) == 8'h00);

  p_irq_needs_gie_r9: assert property (@(posedge clk) disable iff (rst)
    (irq != 8'h00) |-> $past(gie));

  p_write_clears_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !tick) |=> ((rd_data & $past(wr_data)) == 8'h00));

  p_ack_clears_r4: assert property (@(posedge clk) disable iff (rst)
    (!tick && ack != 8'h00) |=> ((rd_data & $past(ack)) == 8'h00));

  p_idle_holds_r8: assert property (@(posedge clk) disable iff (rst)
    (!tick && !wr_en && ack == 8'h00) |=> $stable(rd_data));

  p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
    (tick && c0_ovf_ev && ((wr_en && wr_data[0]) || ack[0])) |=> rd_data[0]);
endmodule

bind tef_flags tef_flags_chk u_chk (.*);

// File: tb/tef_flags_bench.sv
`timescale 1ns/1ps
module tef_flags_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick, gie, wr_en, cap_top_sel;
  logic c0_ovf_ev, c0_hit_a, c0_hit_b, c0_frc_a, c0_frc_b;
  logic c1_ovf_ev, c1_hit_a, c1_hit_b, c1_frc_a, c1_frc_b;
  logic cap_pin_ev, c1_top_ev;
  logic [7:0] irq_en, wr_data, ack, rd_data, irq;

  logic [7:0] exp_flags, exp_irq;
  logic [3:0] exp_pend;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  tef_flags u_tef_flags (.*);

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic quiet();
    tick = 1'b1; wr_en = 1'b0; wr_data = 8'h00; ack = 8'h00;
    c0_ovf_ev = 0; c0_hit_a = 0; c0_hit_b = 0; c0_frc_a = 0; c0_frc_b = 0;
    c1_ovf_ev = 0; c1_hit_a = 0; c1_hit_b = 0; c1_frc_a = 0; c1_frc_b = 0;
    cap_pin_ev = 0; c1_top_ev = 0;
  endtask

  // bench model of the next state, built from R2..R10
  task automatic model_step();
    logic [3:0] hits, frcs, fire;
    logic [7:0] setv, clrv;
    hits = {c1_hit_b, c1_hit_a, c0_hit_b, c0_hit_a};
    frcs = {c1_frc_b, c1_frc_a, c0_frc_b, c0_frc_a};
    fire = tick ? exp_pend : 4'b0;
    if (tick) exp_pend = hits & ~frcs;
    setv = {tick & (cap_top_sel ? c1_top_ev : cap_pin_ev), 1'b0,
            fire[3], fire[2], tick & c1_ovf_ev, fire[1], fire[0], tick & c0_ovf_ev};
    clrv = (wr_en ? wr_data : 8'h00) | ack;
    exp_flags = (setv | (exp_flags & ~clrv)) & 8'hBF;
    exp_irq   = exp_flags & irq_en & {8{gie}};
  endtask

  task automatic cyc(string tag);
    model_step();
    @(posedge clk); #1;
    chk(tag, rd_data, exp_flags);
    chk(tag, irq, exp_irq);
    quiet();
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    quiet();
    gie = 1'b1; irq_en = 8'hFF; cap_top_sel = 1'b0;
    exp_flags = 8'h00; exp_irq = 8'h00; exp_pend = 4'h0;
    repeat (3) @(posedge clk);
    #1; rst = 1'b0;
    chk("R1 reset flags", rd_data, 8'h00);
    chk("R1 reset irq", irq, 8'h00);

    // R8 / R2: overflow and capture positions
    c0_ovf_ev = 1; cyc("R8 t0 ovf");
    chk("R2 t0 ovf at bit0", rd_data, 8'h01);
    chk("R9 irq follows flag", irq, 8'h01);
    cap_pin_ev = 1; cyc("R7 pin capture");
    chk("R2 capture at bit7", rd_data, 8'h81);
    wr_en = 1; wr_data = 8'hFF; cyc("R3 clear all");
    chk("R3 write ones", rd_data, 8'h00);
    c0_ovf_ev = 1; c1_ovf_ev = 1; cyc("R8 both ovf");
    chk("R2 t1 ovf at bit3", rd_data, 8'h09);
    wr_en = 1; wr_data = 8'h08; cyc("R3 partial");
    chk("R3 zero leaves bit0", rd_data, 8'h01);
    wr_en = 1; wr_data = 8'h00; cyc("R3 write zero");
    chk("R3 all zero write", rd_data, 8'h01);
    tick = 0; c1_ovf_ev = 1; cyc("R8 no tick");
    chk("R8 event without tick ignored", rd_data, 8'h01);
    ack = 8'h01; cyc("R4 ack");
    chk("R4 ack clears bit0", rd_data, 8'h00);

    // R5: compare delay counted in ticks
    c0_hit_a = 1; cyc("R5 hit cycle");
    chk("R5 not set on hit tick", rd_data, 8'h00);
    tick = 0; cyc("R5 gap");
    tick = 0; cyc("R5 gap");
    chk("R5 not set during gap", rd_data, 8'h00);
    cyc("R5 next tick");
    chk("R5 set on next tick", rd_data, 8'h02);
    c1_hit_b = 1; cyc("R5 t1 b");
    cyc("R5 t1 b next");
    chk("R2 t1 cmpB at bit5", rd_data, 8'h22);
    wr_en = 1; wr_data = 8'hFF; cyc("R3 clear");

    // R6: forced compare
    c0_hit_b = 1; c0_frc_b = 1; c1_hit_a = 1; c1_frc_a = 1; cyc("R6 forced");
    cyc("R6 forced next");
    cyc("R6 forced next2");
    chk("R6 forced sets nothing", rd_data, 8'h00);

    // R7: capture source select
    cap_top_sel = 1;
    cap_pin_ev = 1; cyc("R7 pin ignored");
    chk("R7 pin ignored in top mode", rd_data, 8'h00);
    c1_top_ev = 1; cyc("R7 top");
    chk("R7 top sets capture", rd_data, 8'h80);
    ack = 8'h80; cyc("R4 ack capture");
    chk("R4 ack clears bit7", rd_data, 8'h00);
    cap_top_sel = 0;
    c1_top_ev = 1; cyc("R7 top ignored");
    chk("R7 top ignored in pin mode", rd_data, 8'h00);

    // R9: gating
    gie = 0; c0_ovf_ev = 1; cyc("R9 gie off");
    chk("R9 no irq without gie", irq, 8'h00);
    gie = 1; irq_en = 8'hFE; cyc("R9 mask");
    chk("R9 masked enable", irq, 8'h00);
    irq_en = 8'hFF; cyc("R9 unmask");
    chk("R9 enabled request", irq, 8'h01);

    // R10: set wins against both clear paths
    wr_en = 1; wr_data = 8'h01; c0_ovf_ev = 1; cyc("R10 write collision");
    chk("R10 set beats write", rd_data, 8'h01);
    ack = 8'h80; cap_pin_ev = 1; cyc("R10 ack collision");
    chk("R10 set beats ack", rd_data, 8'h81);

    // random mix against the model
    void'($urandom(32'h1234_5678));
    for (int i = 0; i < 4000; i++) begin
      tick = ($urandom % 3) != 0;
      gie  = ($urandom % 8) != 0;
      irq_en = $urandom;
      cap_top_sel = ($urandom % 16) == 0 ? ~cap_top_sel : cap_top_sel;
      c0_ovf_ev = ($urandom % 6) == 0;  c1_ovf_ev = ($urandom % 6) == 0;
      c0_hit_a = ($urandom % 5) == 0;   c0_hit_b = ($urandom % 5) == 0;
      c1_hit_a = ($urandom % 5) == 0;   c1_hit_b = ($urandom % 5) == 0;
      c0_frc_a = ($urandom % 4) == 0;   c0_frc_b = ($urandom % 4) == 0;
      c1_frc_a = ($urandom % 4) == 0;   c1_frc_b = ($urandom % 4) == 0;
      cap_pin_ev = ($urandom % 7) == 0; c1_top_ev = ($urandom % 7) == 0;
      wr_en = ($urandom % 5) == 0;      wr_data = $urandom;
      ack = (($urandom % 6) == 0) ? 8'($urandom) : 8'h00;
      cyc("random R3/R4/R10");
    end
    summary();
  end
endmodule